// File: doc/BRIEF.md
# Eight-Channel Interrupt Priority Summary

This block gathers interrupt causes from eight serial channels into one summary view. Every channel has its own set of sticky source flags. A flag is set by an event strobe and dropped by the clearing condition that belongs to that source. The clearing condition is either a register-read strobe or a receive-FIFO-empty level. Channel 0 has two extra sources that the other channels do not have: a timer expiry and a general-purpose pin event.

From the flags the block produces three things:
- an 8-bit pending byte, one bit per channel;
- a 24-bit field that holds one 3-bit priority code per channel;
- one interrupt line that is the OR of all pending bits.

An interrupt handler reads the pending byte to find the busy channels, reads the code of each one, and services the cause that the code names.

Each source flag is a two-state machine. The states are IDLE and HELD. The SET transition (IDLE to HELD) happens on the source's event strobe. The CLEAR transition (HELD to IDLE) happens on the source's clearing condition, but only when no event arrives in the same cycle. In every other case the flag keeps its state. Flags are registered. The pending byte, the code field and the interrupt line are decoded combinationally from the flags, so they change right after the clock edge that registers an event or a clear.

Top module: `irq_summary_enc`

## Requirements
- R1: During and after reset every flag is IDLE, so `pend` is 0, `codes` is 0 and `irq` is 0.
- R2: `pend[k]` is 1 exactly when channel k holds any flag, the wake-up flag included. `irq` is the OR of all `pend` bits.
- R3: The code of channel k sits in `codes[3k+2:3k]`.
- R4: The code values are as follows. Receive-ready or line-status gives 3'b001. Receive timeout gives 3'b010. Transmit ready gives 3'b011. Modem delta or flow/special-character gives 3'b100. A channel with only the wake-up flag, or with no flag, gives 3'b000.
- R5: When several flags are held, the smallest nonzero code that applies is reported. Code 3'b101 never appears.
- R6: On channel 0, the pin event gives 3'b110 and the timer expiry gives 3'b111. These rank below all other causes, and the pin ranks above the timer. No other channel ever reports 3'b110 or 3'b111.
- R7: A `pend_rd` strobe clears the wake-up flag of every channel and leaves all other flags alone.
- R8: The receive-ready and receive-timeout flags of channel k clear only while `rxfifo_empty[k]` is high.
- R9: `lstat_rd[k]` clears only the line-status flag of channel k. `stat_rd[k]` clears only the transmit-ready and flow/special-character flags of channel k.
- R10: `modem_rd[k]` clears the modem-delta flag of channel k. `tmr_rd` clears the timer flag and `pin_rd` clears the pin flag.
- R11: If an event and its clearing condition arrive in the same cycle, the flag ends HELD.
- R12: Outputs follow the flags one edge after a strobe. `irq` drops right after the edge that clears the last held flag, and it never rises in a cycle with no event strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_ev | input | 8 | Wake-up event, one bit per channel |
| rxrdy_ev | input | 8 | Receive data ready event |
| lstat_ev | input | 8 | Receive line-status error event |
| rxto_ev | input | 8 | Receive timeout event |
| txrdy_ev | input | 8 | Transmit ready event |
| modem_ev | input | 8 | Modem-status or handshake-line delta event |
| flow_ev | input | 8 | Xon/Xoff or special-character detect event |
| tmr_ev | input | 1 | Timer expiry event (channel 0) |
| pin_ev | input | 1 | General-purpose pin event (channel 0) |
| pend_rd | input | 1 | Read strobe of the pending byte |
| rxfifo_empty | input | 8 | Receive FIFO empty level per channel |
| lstat_rd | input | 8 | Line-status register read strobe per channel |
| stat_rd | input | 8 | Channel status register read strobe per channel |
| modem_rd | input | 8 | Modem-status register read strobe per channel |
| tmr_rd | input | 1 | Timer control register read strobe |
| pin_rd | input | 1 | Pin level register read strobe |
| pend | output | 8 | Per-channel pending bits |
| codes | output | 24 | Packed 3-bit priority codes |
| irq | output | 1 | Aggregate interrupt |

## Verification
The assertions take three things for granted:
- strobes are sampled only at clock edges after reset is released;
- the two channel-0-only sources are tied off on the other channels;
- an event that meets its own clearing condition in the same cycle is meant to leave the flag HELD.

The stimulus drives every strobe between clock edges and holds it for exactly one edge. It applies every subset of event strobes to each channel, then applies every clearing condition together. Directed sequences then fire each clearing strobe alone, so that its effect on other flags stays visible at the ports.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    localparam int CODE_W = 3;
    localparam int NSRC   = 9;

    // source index inside a channel's flag vector
    localparam int SRC_WAKE = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_LST  = 2;
    localparam int SRC_RTO  = 3;
    localparam int SRC_TXR  = 4;
    localparam int SRC_MDM  = 5;
    localparam int SRC_FLW  = 6;
    localparam int SRC_PIN  = 7;
    localparam int SRC_TMR  = 8;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE  = 3'b000,
        CODE_RX    = 3'b001,
        CODE_RXTO  = 3'b010,
        CODE_TX    = 3'b011,
        CODE_MODEM = 3'b100,
        CODE_PIN   = 3'b110,
        CODE_TIMER = 3'b111
    } src_code_e;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_HELD = 1'b1
    } flag_st_e;

endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag
    import irq_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o
);

    flag_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (set_i)           state_d = FL_HELD;
            FL_HELD: if (clr_i && !set_i) state_d = FL_IDLE;
        endcase
    end

    always_comb held_o = (state_q == FL_HELD);

    // R11: a set strobe always leaves the flag held
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o);

    // R9: a clear with no competing set empties the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !held_o);

    // R12: a flag never rises without its set strobe
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !set_i) |=> !held_o);

endmodule

// File: rtl/irq_src_encoder.sv
module irq_src_encoder
    import irq_enc_pkg::*;
(
    input  logic [NSRC-1:0]   held_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);

    src_code_e code;

    always_comb begin
        if (held_i[SRC_RXD] || held_i[SRC_LST])      code = CODE_RX;
        else if (held_i[SRC_RTO])                    code = CODE_RXTO;
        else if (held_i[SRC_TXR])                    code = CODE_TX;
        else if (held_i[SRC_MDM] || held_i[SRC_FLW]) code = CODE_MODEM;
        else if (held_i[SRC_PIN])                    code = CODE_PIN;
        else if (held_i[SRC_TMR])                    code = CODE_TIMER;
        else                                         code = CODE_NONE;
    end

    assign code_o = code;
    assign any_o  = |held_i;

endmodule

// File: rtl/irq_chan_slice.sv
module irq_chan_slice
    import irq_enc_pkg::*;
#(
    parameter bit HAS_EXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   ev_i,
    input  logic [NSRC-1:0]   clr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              pend_o
);

    logic [NSRC-1:0] held;

    for (genvar s = 0; s < NSRC; s++) begin : g_flag
        irq_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev_i[s]),
            .clr_i  (clr_i[s]),
            .held_o (held[s])
        );
    end

    irq_src_encoder u_enc (
        .held_i (held),
        .code_o (code_o),
        .any_o  (pend_o)
    );

    // R5: reserved code never emitted
    a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        code_o != 3'b101);

    // R5: receive causes outrank everything
    a_r5_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
        (held[SRC_RXD] || held[SRC_LST]) |-> code_o == 3'b001);

    // R2: a nonzero code implies the pending bit
    a_r2_code_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != 3'b000) |-> pend_o);

    // R6: channel-0-only codes stay off other channels
    a_r6_ext_only_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_EXT |-> (code_o[2:1] != 2'b11));

endmodule

// File: rtl/irq_summary_enc.sv
module irq_summary_enc
    import irq_enc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      wake_ev,
    input  logic [NCH-1:0]      rxrdy_ev,
    input  logic [NCH-1:0]      lstat_ev,
    input  logic [NCH-1:0]      rxto_ev,
    input  logic [NCH-1:0]      txrdy_ev,
    input  logic [NCH-1:0]      modem_ev,
    input  logic [NCH-1:0]      flow_ev,
    input  logic                tmr_ev,
    input  logic                pin_ev,
    input  logic                pend_rd,
    input  logic [NCH-1:0]      rxfifo_empty,
    input  logic [NCH-1:0]      lstat_rd,
    input  logic [NCH-1:0]      stat_rd,
    input  logic [NCH-1:0]      modem_rd,
    input  logic                tmr_rd,
    input  logic                pin_rd,
    output logic [NCH-1:0]      pend,
    output logic [NCH*CODE_W-1:0] codes,
    output logic                irq
);

    localparam int FIELD_W = NCH * CODE_W;

    logic [NSRC-1:0] ev_v  [NCH];
    logic [NSRC-1:0] clr_v [NCH];
    logic [FIELD_W-1:0] field;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam bit EXT = (k == 0);
        logic ext_ev_t, ext_ev_p, ext_rd_t, ext_rd_p;

        if (EXT) begin : g_ext
            assign ext_ev_t = tmr_ev;
            assign ext_ev_p = pin_ev;
            assign ext_rd_t = tmr_rd;
            assign ext_rd_p = pin_rd;
        end else begin : g_noext
            assign ext_ev_t = 1'b0;
            assign ext_ev_p = 1'b0;
            assign ext_rd_t = 1'b0;
            assign ext_rd_p = 1'b0;
        end

        assign ev_v[k] = {ext_ev_t, ext_ev_p, flow_ev[k], modem_ev[k],
                          txrdy_ev[k], rxto_ev[k], lstat_ev[k],
                          rxrdy_ev[k], wake_ev[k]};

        assign clr_v[k] = {ext_rd_t, ext_rd_p, stat_rd[k], modem_rd[k],
                           stat_rd[k], rxfifo_empty[k], lstat_rd[k],
                           rxfifo_empty[k], pend_rd};

        irq_chan_slice #(.HAS_EXT(EXT)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_i   (ev_v[k]),
            .clr_i  (clr_v[k]),
            .code_o (field[CODE_W*k +: CODE_W]),
            .pend_o (pend[k])
        );
    end

    assign codes = field;
    assign irq   = |pend;

    logic any_ev;
    assign any_ev = |{wake_ev, rxrdy_ev, lstat_ev, rxto_ev, txrdy_ev,
                      modem_ev, flow_ev, tmr_ev, pin_ev};

    // R12: the summary line cannot rise without an event
    a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !any_ev) |=> !irq);

    // R1: quiet right after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));

endmodule

// File: tb/irq_summary_enc_tb_top.sv
`timescale 1ns/1ps
module irq_summary_enc_tb_top;

    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [8:0] ev_s [NCH];
    logic [8:0] mdl  [NCH];
    logic       pend_rd, tmr_rd, pin_rd;
    logic [NCH-1:0] rxfifo_empty, lstat_rd, stat_rd, modem_rd;
    logic [NCH-1:0] wake_ev, rxrdy_ev, lstat_ev, rxto_ev, txrdy_ev, modem_ev, flow_ev;
    logic [NCH-1:0] pend;
    logic [NCH*3-1:0] codes;
    logic irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            wake_ev[k]  = ev_s[k][0];
            rxrdy_ev[k] = ev_s[k][1];
            lstat_ev[k] = ev_s[k][2];
            rxto_ev[k]  = ev_s[k][3];
            txrdy_ev[k] = ev_s[k][4];
            modem_ev[k] = ev_s[k][5];
            flow_ev[k]  = ev_s[k][6];
        end
    end

    irq_summary_enc #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wake_ev(wake_ev), .rxrdy_ev(rxrdy_ev), .lstat_ev(lstat_ev),
        .rxto_ev(rxto_ev), .txrdy_ev(txrdy_ev), .modem_ev(modem_ev),
        .flow_ev(flow_ev), .tmr_ev(ev_s[0][8]), .pin_ev(ev_s[0][7]),
        .pend_rd(pend_rd), .rxfifo_empty(rxfifo_empty), .lstat_rd(lstat_rd),
        .stat_rd(stat_rd), .modem_rd(modem_rd), .tmr_rd(tmr_rd), .pin_rd(pin_rd),
        .pend(pend), .codes(codes), .irq(irq)
    );

    function automatic logic [2:0] ecode(input logic [8:0] f);
        if (f[1] | f[2])      return 3'b001;
        else if (f[3])        return 3'b010;
        else if (f[4])        return 3'b011;
        else if (f[5] | f[6]) return 3'b100;
        else if (f[7])        return 3'b110;
        else if (f[8])        return 3'b111;
        return 3'b000;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic quiet();
        for (int k = 0; k < NCH; k++) ev_s[k] = '0;
        pend_rd = 0; tmr_rd = 0; pin_rd = 0;
        rxfifo_empty = '0; lstat_rd = '0; stat_rd = '0; modem_rd = '0;
    endtask

    // one clock edge: update the model from the requirements, then compare
    task automatic cycle(input string tag);
        logic [NCH-1:0] ep;
        logic [NCH*3-1:0] ec;
        for (int k = 0; k < NCH; k++) begin
            logic [8:0] c;
            logic [8:0] e;
            e = ev_s[k];
            if (k != 0) e[8:7] = 2'b00;
            c = {(k == 0) & tmr_rd, (k == 0) & pin_rd, stat_rd[k], modem_rd[k],
                 stat_rd[k], rxfifo_empty[k], lstat_rd[k], rxfifo_empty[k], pend_rd};
            mdl[k] = e | (mdl[k] & ~c);
        end
        @(posedge clk); #1;
        for (int k = 0; k < NCH; k++) begin
            ep[k] = |mdl[k];
            ec[3*k +: 3] = ecode(mdl[k]);
        end
        chk(tag, "pend (R2)", 32'(pend), 32'(ep));
        chk(tag, "codes (R3)", 32'(codes), 32'(ec));
        chk(tag, "irq (R12)", 32'(irq), 32'(|ep));
        quiet();
    endtask

    task automatic clear_all(input string tag);
        pend_rd = 1; tmr_rd = 1; pin_rd = 1;
        rxfifo_empty = '1; lstat_rd = '1; stat_rd = '1; modem_rd = '1;
        cycle(tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        quiet();
        for (int k = 0; k < NCH; k++) mdl[k] = '0;
        // R1: reset state
        ev_s[2] = 9'h1FF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "pend in reset", 32'(pend), 0);
        chk("R1", "codes in reset", 32'(codes), 0);
        quiet();
        @(negedge clk); rst_n = 1; #1;
        chk("R1", "irq after reset", 32'(irq), 0);

        // R4 R5 R6: every event subset on every channel, then full clear
        for (int k = 0; k < NCH; k++) begin
            int top_m;
            top_m = (k == 0) ? 512 : 128;
            for (int m = 1; m < top_m; m++) begin
                ev_s[k] = 9'(m);
                cycle("R5");
                clear_all("R12");
            end
        end

        // R6: pin above timer on channel 0
        ev_s[0] = 9'h180; cycle("R6");
        chk("R6", "ch0 code", 32'(codes[2:0]), 32'h6);
        pin_rd = 1; cycle("R10");
        chk("R10", "ch0 code after pin read", 32'(codes[2:0]), 32'h7);
        tmr_rd = 1; cycle("R10");
        chk("R10", "irq after timer read", 32'(irq), 0);

        // R7: wake-up only, cleared by pending read, other flags kept
        ev_s[3] = 9'h001; ev_s[5] = 9'h011; cycle("R7");
        chk("R7", "ch3 code", 32'(codes[11:9]), 0);
        pend_rd = 1; cycle("R7");
        chk("R7", "pend after read", 32'(pend), 32'h20);
        clear_all("R7");

        // R8: receive flags ignore other reads, clear on empty
        ev_s[2] = 9'h00A; cycle("R8");
        stat_rd = '1; lstat_rd = '1; modem_rd = '1; pend_rd = 1; cycle("R8");
        chk("R8", "ch2 code held", 32'(codes[8:6]), 32'h1);
        rxfifo_empty[1] = 1; cycle("R8");
        chk("R8", "ch2 kept by other empty", 32'(codes[8:6]), 32'h1);
        rxfifo_empty[2] = 1; cycle("R8");
        chk("R8", "ch2 cleared", 32'(pend[2]), 0);

        // R9: line status vs status reads
        ev_s[4] = 9'h054; cycle("R9");
        stat_rd[4] = 1; cycle("R9");
        chk("R9", "ch4 line kept", 32'(codes[14:12]), 32'h1);
        lstat_rd[4] = 1; cycle("R9");
        chk("R9", "ch4 idle", 32'(pend[4]), 0);

        // R10: modem read
        ev_s[6] = 9'h030; cycle("R10");
        modem_rd[6] = 1; cycle("R10");
        chk("R10", "ch6 tx remains", 32'(codes[20:18]), 32'h3);
        stat_rd[6] = 1; cycle("R10");

        // R11: event beats simultaneous clear
        ev_s[7] = 9'h010; stat_rd[7] = 1; cycle("R11");
        chk("R11", "ch7 held", 32'(codes[23:21]), 32'h3);
        stat_rd[7] = 1; cycle("R12");
        chk("R12", "irq dropped", 32'(irq), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule